// File: doc/BRIEF.md
# Latched-Address Byte Memory Device Model

This block is a clock-sampled, synthesizable model of the device side of a byte-wide memory that has an asynchronous, SRAM-like control interface. The memory takes its address, and for writes its data, at control edges rather than as levels. It oversamples two chip enables (one active low, one active high), an active-low write strobe, an active-low output strobe, a 17-bit address and an 8-bit data bus. From these it finds the latching edges, decodes the operating mode, and performs reads and writes on an internal array whose depth is a parameter.

A read presents its byte only after a configurable number of clocks, counted from the edge that latched the address. Until then the output enable is already active but the data bus shows zero. The model also watches the time between selections and the length of each selection. It records the first breach of either minimum in a sticky flag with a cause code, so a bus controller under test can be checked for protocol timing.

All inputs pass through a two-flop synchronizer. Every input change therefore reaches the decode logic two clocks later, and the registered outputs change one clock after that.

Top module: `psram_model`

## Requirements
- R1: After reset, `data_oe_o` is 0, `data_o` is 0, `viol_o` is 0 and `viol_cause_o` is 0.
- R2: `data_oe_o` is 1 only while `ce1_n_i`=0, `ce2_i`=1, `we_n_i`=1 and `oe_n_i`=0, seen three clocks after the inputs change. It is 0 when `ce1_n_i`=1 or `ce2_i`=0, during any write, and once `oe_n_i` returns high.
- R3: When the chip becomes selected (`ce1_n_i` falls or `ce2_i` rises) while `we_n_i` is already low, the address and data present at that edge are written.
- R4: A falling `we_n_i` while the chip stays selected writes the address and data present at that edge. Changes to address or data while `we_n_i` stays low have no effect.
- R5: A falling `oe_n_i` while the chip stays selected and `we_n_i` is high latches the read address. Later address changes do not alter the returned byte.
- R6: When the chip becomes selected with `oe_n_i` already low and `we_n_i` high, the address at the selection edge is latched for a read. Either enable may make the selection edge.
- R7: After a read latch, `data_o` is 0 until ACCESS_LAT clocks after the latching clock edge. From that edge on it shows the stored byte while the read mode holds.
- R8: If the chip is selected again after fewer than PRECHARGE_MIN deselected samples, `viol_o` rises and `viol_cause_o` becomes 1. Exactly PRECHARGE_MIN samples is legal.
- R9: If a selection lasts fewer than ACTIVE_MIN samples, `viol_o` rises at its end and `viol_cause_o` becomes 2. Exactly ACTIVE_MIN samples is legal.
- R10: Once set, `viol_o` and `viol_cause_o` hold, keeping the first cause, until reset clears them.
- R11: Only the low log2(DEPTH) address bits select a location. Addresses differing only in higher bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output strobe, active low |
| addr_i | input | 17 | Byte address |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data toward the bus, zero while invalid |
| data_oe_o | output | 1 | Output driver enable (1 = drive, 0 = high impedance) |
| viol_o | output | 1 | Sticky timing violation flag |
| viol_cause_o | output | 2 | First violation cause: 0 none, 1 precharge, 2 active time |

## Verification
On every cycle, assertions check that the driver stays off while the chip is deselected or being written, and that a freshly latched read never shows a byte in the following clock. They also check that the violation flag and its cause never change once set, that flag and cause agree, and that a too-short selection always raises the flag. Whether the right byte comes back can only be shown by the bench's scenarios. These cover edge-latched addresses, address and data wiggled after the latch, aliasing, the exact latency boundary, and the exact-minimum versus one-short timing cases.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_PRECHARGE = 2'd1,
        CAUSE_ACTIVE    = 2'd2
    } viol_cause_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
    } ctrl_t;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/psram_sync.sv
module psram_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/psram_timing.sv
module psram_timing
    import psram_pkg::*;
#(
    parameter int PRECHARGE_MIN = 5,
    parameter int ACTIVE_MIN    = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       sel_prev_i,
    output logic       viol_o,
    output logic [1:0] cause_o
);

    localparam int PRE_W = $clog2(PRECHARGE_MIN + 1);
    localparam int ACT_W = $clog2(ACTIVE_MIN + 1);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRECHARGE_MIN);
    localparam logic [ACT_W-1:0] ACT_LIM = ACT_W'(ACTIVE_MIN);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [ACT_W-1:0] act;
        logic             viol;
        viol_cause_e      cause;
    } tim_state_t;

    tim_state_t st_d, st_q;
    logic       rise, fall;

    always_comb begin
        rise = sel_i && !sel_prev_i;
        fall = !sel_i && sel_prev_i;
        st_d = st_q;

        // selection length, counted in samples, saturating at the minimum
        if (rise)
            st_d.act = ACT_W'(1);
        else if (sel_i && st_q.act < ACT_LIM)
            st_d.act = st_q.act + 1'b1;

        // deselected length, counted in samples, saturating at the minimum
        if (fall)
            st_d.pre = PRE_W'(1);
        else if (!sel_i && st_q.pre < PRE_LIM)
            st_d.pre = st_q.pre + 1'b1;

        if (!st_q.viol) begin
            if (rise && st_q.pre < PRE_LIM) begin
                st_d.viol  = 1'b1;
                st_d.cause = CAUSE_PRECHARGE;
            end else if (fall && st_q.act < ACT_LIM) begin
                st_d.viol  = 1'b1;
                st_d.cause = CAUSE_ACTIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre   <= PRE_LIM;
            st_q.act   <= '0;
            st_q.viol  <= 1'b0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_o  = st_q.viol;
    assign cause_o = st_q.cause;

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o); // R10
    AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> $stable(cause_o)); // R10
    AST_FLAG_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o == (cause_o != 2'd0)); // R8
    AST_SHORT_ACTIVE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_prev_i && !sel_i && st_q.act < ACT_LIM) |=> viol_o); // R9

endmodule

// File: rtl/psram_model.sv
module psram_model
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 256,
    parameter int ACCESS_LAT    = 3,
    parameter int PRECHARGE_MIN = 5,
    parameter int ACTIVE_MIN    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              viol_o,
    output logic [1:0]        viol_cause_o
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(ACCESS_LAT + 1);
    localparam int BUS_W = CTRL_W + ADDR_W + DATA_W;
    // idle bus: ce1_n high, ce2 low, we_n high, oe_n high
    localparam logic [BUS_W-1:0] BUS_IDLE = {4'b1011, {(ADDR_W + DATA_W){1'b0}}};

    typedef struct packed {
        logic              sel_p;
        logic              we_n_p;
        logic              oe_n_p;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [DATA_W-1:0] rd;
        logic              oe;
    } dev_state_t;

    logic [BUS_W-1:0]  bus_raw, bus_s;
    ctrl_t             ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    dev_state_t        st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              sel_s, rd_mode, ce_edge, we_edge, oe_edge, wr_en, rd_start;

    assign bus_raw = {ce1_n_i, ce2_i, we_n_i, oe_n_i, addr_i, data_i};

    psram_sync #(
        .W       (BUS_W),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (bus_raw),
        .sync_o (bus_s)
    );

    assign ctl_s  = ctrl_t'(bus_s[BUS_W-1 -: CTRL_W]);
    assign addr_s = bus_s[DATA_W +: ADDR_W];
    assign data_s = bus_s[DATA_W-1:0];

    generate
        if (ADDR_W > IDX_W) begin : g_alias
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr_s[ADDR_W-1:IDX_W];
        end
    endgenerate

    always_comb begin
        sel_s    = !ctl_s.ce1_n && ctl_s.ce2;
        rd_mode  = sel_s && ctl_s.we_n && !ctl_s.oe_n;
        ce_edge  = sel_s && !st_q.sel_p;
        we_edge  = sel_s && st_q.sel_p && !ctl_s.we_n && st_q.we_n_p;
        oe_edge  = sel_s && st_q.sel_p && ctl_s.we_n && !ctl_s.oe_n && st_q.oe_n_p;
        wr_en    = (ce_edge && !ctl_s.we_n) || we_edge;
        rd_start = (ce_edge || oe_edge) && rd_mode;

        st_d        = st_q;
        st_d.sel_p  = sel_s;
        st_d.we_n_p = ctl_s.we_n;
        st_d.oe_n_p = ctl_s.oe_n;
        st_d.oe     = rd_mode;

        if (ce_edge || we_edge || oe_edge)
            st_d.idx = addr_s[IDX_W-1:0];

        if (!rd_mode) begin
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
        end else if (rd_start) begin
            st_d.cnt   = CNT_W'(ACCESS_LAT);
            st_d.valid = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.valid = 1'b1;
                st_d.rd    = mem[st_q.idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_p  <= 1'b0;
            st_q.we_n_p <= 1'b1;
            st_q.oe_n_p <= 1'b1;
            st_q.idx    <= '0;
            st_q.cnt    <= '0;
            st_q.valid  <= 1'b0;
            st_q.rd     <= '0;
            st_q.oe     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // storage array: no reset, written at the latching edge
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr_s[IDX_W-1:0]] <= data_s;
    end

    assign data_oe_o = st_q.oe;
    assign data_o    = (st_q.oe && st_q.valid) ? st_q.rd : '0;

    psram_timing #(
        .PRECHARGE_MIN (PRECHARGE_MIN),
        .ACTIVE_MIN    (ACTIVE_MIN)
    ) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_s),
        .sel_prev_i (st_q.sel_p),
        .viol_o     (viol_o),
        .cause_o    (viol_cause_o)
    );

    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !data_oe_o); // R2
    AST_HIZ_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && !ctl_s.we_n) |=> !data_oe_o); // R2
    AST_INVALID_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (data_o == '0)); // R7

endmodule

// File: tb/test_psram_model.sv
`timescale 1ns/1ps
module test_psram_model;

    localparam int ACC   = 3;
    localparam int PRE   = 5;
    localparam int ACT   = 30;
    localparam int DEPTH = 256;

    typedef struct packed {
        logic [1:0]  kind;   // 0 WE write, 1 CE write, 2 OE read, 3 CE read
        logic [16:0] addr;
        logic [7:0]  data;   // write data or expected read byte
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 17'h00010, 8'h3C},   // R4 write
        '{2'd1, 17'h1FF21, 8'hC3},   // R3 write, high bits set (R11)
        '{2'd0, 17'h00007, 8'h5A},   // R4 write
        '{2'd2, 17'h00010, 8'h3C},   // R5 read
        '{2'd3, 17'h00021, 8'hC3},   // R6 read of aliased location (R11)
        '{2'd2, 17'h00007, 8'h5A},   // R5 read
        '{2'd0, 17'h00010, 8'h81},   // R4 overwrite
        '{2'd3, 17'h00010, 8'h81}    // R6 read of overwrite
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  data_o;
    logic        data_oe_o, viol_o;
    logic [1:0]  viol_cause_o;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    psram_model #(
        .DEPTH         (DEPTH),
        .ACCESS_LAT    (ACC),
        .PRECHARGE_MIN (PRE),
        .ACTIVE_MIN    (ACT)
    ) i_psram_model (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce1_n_i      (ce1_n),
        .ce2_i        (ce2),
        .we_n_i       (we_n),
        .oe_n_i       (oe_n),
        .addr_i       (addr),
        .data_i       (wdata),
        .data_o       (data_o),
        .data_oe_o    (data_oe_o),
        .viol_o       (viol_o),
        .viol_cause_o (viol_cause_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(PRE + 3);
    endtask

    // called one negedge after the edge that starts the read was driven
    task automatic read_tail(input logic [7:0] exp, input string tag);
        wait_n(2);
        chk({tag, " R2 driver on"}, data_oe_o, 1);
        chk({tag, " R7 invalid early"}, data_o, 0);
        wait_n(ACC - 1);
        chk({tag, " R7 invalid one before latency"}, data_o, 0);
        wait_n(1);
        chk({tag, " byte after latency R7 (R3 R4 R11 stored data)"}, data_o, exp);
        wait_n(ACT);
        oe_n = 1'b1;
        wait_n(3);
        chk({tag, " R2 off after oe high"}, data_oe_o, 0);
        ce1_n = 1'b1;
        ce2   = 1'b1;
        wait_n(PRE + 3);
    endtask

    task automatic run_vec(input vec_t v);
        case (v.kind)
            2'd0: begin // WE-controlled write
                @(negedge clk); ce1_n = 1'b0;
                wait_n(4);
                addr = v.addr; wdata = v.data; we_n = 1'b0;
                wait_n(3);
                chk("R2 off during write", data_oe_o, 0);
                wait_n(1);
                wdata = ~v.data; addr = v.addr ^ 17'h1;   // R4 ignored changes
                wait_n(ACT);
                we_n = 1'b1;
                wait_n(2);
                ce1_n = 1'b1;
                wait_n(PRE + 3);
            end
            2'd1: begin // CE-controlled write
                @(negedge clk); addr = v.addr; wdata = v.data; we_n = 1'b0;
                wait_n(3);
                ce1_n = 1'b0;
                wait_n(3);
                chk("R2 off during ce write", data_oe_o, 0);
                wait_n(1);
                wdata = ~v.data; addr = v.addr ^ 17'h1;
                wait_n(ACT);
                ce1_n = 1'b1;
                wait_n(2);
                we_n = 1'b1;
                wait_n(PRE + 3);
            end
            2'd2: begin // OE-controlled read
                @(negedge clk); ce1_n = 1'b0;
                wait_n(4);
                addr = v.addr; oe_n = 1'b0;
                wait_n(1);
                addr = v.addr ^ 17'h1;                    // R5 ignored change
                read_tail(v.data, "R5");
            end
            default: begin // CE-controlled read
                @(negedge clk); addr = v.addr; oe_n = 1'b0;
                wait_n(3);
                ce1_n = 1'b0;
                wait_n(1);
                addr = v.addr ^ 17'h1;
                read_tail(v.data, "R6");
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        chk("R1 oe at reset", data_oe_o, 0);
        chk("R1 data at reset", data_o, 0);
        chk("R1 viol at reset", viol_o, 0);
        chk("R1 cause at reset", viol_cause_o, 0);
        rst_n = 1'b1;
        wait_n(PRE + 3);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);
        chk("R8 R9 no violation in legal traffic", viol_o, 0);

        // R2: CE2 low keeps the driver off, then CE2 rising starts a read (R6)
        @(negedge clk); ce1_n = 1'b0; ce2 = 1'b0; oe_n = 1'b0; addr = 17'h00007;
        wait_n(6);
        chk("R2 off with ce2 low", data_oe_o, 0);
        ce2 = 1'b1;
        wait_n(1);
        read_tail(8'h5A, "R6 ce2");

        // R8/R9 boundaries: exactly minimum active and precharge are legal
        @(negedge clk); ce1_n = 1'b0;
        wait_n(ACT);
        ce1_n = 1'b1;
        wait_n(PRE);
        ce1_n = 1'b0;
        wait_n(ACT + 2);
        ce1_n = 1'b1;
        wait_n(PRE + 3);
        chk("R9 R8 exact minimum no flag", viol_o, 0);
        chk("R9 R8 exact minimum cause", viol_cause_o, 0);

        // R8: short precharge
        @(negedge clk); ce1_n = 1'b0;
        wait_n(ACT + 2);
        ce1_n = 1'b1;
        wait_n(PRE - 1);
        ce1_n = 1'b0;
        wait_n(5);
        chk("R8 flag", viol_o, 1);
        chk("R8 cause", viol_cause_o, 1);
        wait_n(ACT);
        ce1_n = 1'b1;
        wait_n(PRE + 3);

        // R10: later short active keeps the first cause
        @(negedge clk); ce1_n = 1'b0;
        wait_n(5);
        ce1_n = 1'b1;
        wait_n(PRE + 3);
        chk("R10 flag held", viol_o, 1);
        chk("R10 first cause kept", viol_cause_o, 1);

        do_reset();
        chk("R10 cleared by reset flag", viol_o, 0);
        chk("R10 cleared by reset cause", viol_cause_o, 0);

        // R9: active one sample short
        @(negedge clk); ce1_n = 1'b0;
        wait_n(ACT - 1);
        ce1_n = 1'b1;
        wait_n(5);
        chk("R9 flag", viol_o, 1);
        chk("R9 cause", viol_cause_o, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule